// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer wrapped around an external sample-and-convert core. A write to its mode/channel register launches a sequence of four or eight conversions. The sequence either repeats one input channel or walks a group of channels. For every conversion the block counts out a sample window in internal clock ticks, drives the channel multiplexer select, holds a conversion request until the core answers with a done pulse and eight bits of data, and files the data in a result slot.

Software-facing state is a 16-bit status word: a sequence-complete flag, a pointer to the next slot to be written, and one completion flag per slot. It also has a per-slot result read port and an interrupt output. In one-shot mode the sequencer stops after one pass. In continuous mode it keeps cycling and raises the complete flag at the end of the first pass. A power enable gates all sequencing.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After a synchronous reset the status word is 0, `conv_req` is 0 and `irq` is 0.
- R2: With `pwr_en` high, a `cfg_we` pulse starts a new sequence. If a sequence is already running, it is aborted. On the next cycle status bit 15, pointer bits 10..8 and flag bits 7..0 all read 0.
- R3: `cfg_len8`=0 gives 4 conversions per pass into slots 0..3, and `cfg_len8`=1 gives 8 conversions into slots 0..7. A finished one-shot pass leaves flags 0x0F or 0xFF respectively.
- R4: When `cfg_multi`=0, every conversion of the pass requests channel `cfg_sel[3:0]`.
- R5: When `cfg_multi`=1 and the length is 4, slot k uses channel {sel[3:2],k[1:0]}. When the length is 8, slot k uses channel {sel[3],k[2:0]}.
- R6: Status bits 10..8 hold the index of the slot written next. The index returns to 0 after the last slot of a pass.
- R7: Status bit k (k=0..7) is set when slot k is written. It is cleared by `rd_en` with `rd_slot`=k, unless a write to that slot occurs in the same cycle, in which case the write wins.
- R8: Status bit 15 is set when the last slot of a pass is written. With `cfg_scan`=1 conversions continue afterwards, and with `cfg_scan`=0 the block goes idle. A `scf_clr` pulse clears the bit unless it is being set in the same cycle.
- R9: Each request is preceded by a sample window of (2 << `smp_sel`) × D clock cycles, where D = 2·`prs_sel`+2 for codes 1..7 and D = 4 for any other code. `conv_req` stays high until the cycle `conv_done` is seen.
- R10: While `pwr_en` is 0 the sequencer is idle, `conv_req` stays 0 and `cfg_we` has no effect.
- R11: `irq` equals `irq_en` AND status bit 15.
- R12: `rd_data` combinationally shows the last value stored in slot `rd_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Power enable for the sequencer |
| irq_en | input | 1 | Interrupt enable |
| smp_sel | input | 2 | Sample window code |
| prs_sel | input | 5 | Clock divider code |
| cfg_we | input | 1 | Mode/channel register write strobe (start or abort) |
| cfg_len8 | input | 1 | 0 = four conversions, 1 = eight |
| cfg_scan | input | 1 | 0 = one pass, 1 = continuous |
| cfg_multi | input | 1 | 0 = single channel, 1 = channel group |
| cfg_sel | input | 4 | Channel / group select |
| scf_clr | input | 1 | Write-one clear of the complete flag |
| rd_en | input | 1 | Result read strobe (clears that slot's flag) |
| rd_slot | input | 3 | Result slot being read |
| rd_data | output | 8 | Result of slot `rd_slot` |
| conv_req | output | 1 | Conversion request to the core |
| conv_chan | output | 4 | Multiplexer channel select |
| conv_done | input | 1 | Core finished a conversion |
| conv_data | input | 8 | Core conversion result |
| status | output | 16 | {complete, 4'b0, next slot, slot flags} |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check several properties on every cycle. A mode write always leaves a zeroed status word behind it. The pointer never leaves the four-slot range in short mode. A grouped request stays inside the selected group. A written slot shows its flag on the next cycle. An unpowered sequencer never requests. The sample countdown never wraps. Several behaviours only show up in the bench's scenarios against its cycle model: the exact length of each sample window for each divider code, the slot contents, continuous repetition after the first pass, the read-clear and set-wins ordering, and the abort in mid-pass.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: one sequencer state at a time; no other block imports these types.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SAMPLE = 2'd1,
        SQ_CONV   = 2'd2
    } seq_state_e;

    localparam int STAT_W       = 16;
    localparam int STAT_SCF_BIT = 15;
endpackage

// File: rtl/adc_sample_timer.sv
// Sample window countdown.
// On load it computes (2 << smp) * divider - 1 and counts down to zero when dec is high.
// Assumes: the caller raises dec only while it is waiting, and at most 256 ticks per window.
module adc_sample_timer #(
    parameter int PRS_W = 5,
    parameter int SMP_W = 2,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [SMP_W-1:0] smp,
    input  logic [PRS_W-1:0] prs,
    output logic             zero
);
    localparam int PROD_W = 2 * CNT_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  div_v;
    logic [CNT_W-1:0]  per_v;
    logic [PROD_W-1:0] prod_v;
    logic [CNT_W-1:0]  load_v;

    // Window length from the divider and sample codes; illegal divider codes fall back to 4.
    always_comb begin
        if (prs >= PRS_W'(1) && prs <= PRS_W'(7))
            div_v = CNT_W'({prs, 1'b0}) + CNT_W'(2);
        else
            div_v = CNT_W'(4);
        per_v  = CNT_W'(2) << smp;
        prod_v = PROD_W'(div_v) * PROD_W'(per_v);
        load_v = CNT_W'(prod_v) - CNT_W'(1);
    end

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_v;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign zero = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/adc_chan_map.sv
// Maps the configured select and the current slot to the multiplexer channel.
// Assumes: SLOTS is 8, so 3 pointer bits address the slots, and CH_W is 4.
module adc_chan_map #(
    parameter int CH_W  = 4,
    parameter int PTR_W = 3
) (
    input  logic             multi,
    input  logic             len8,
    input  logic [CH_W-1:0]  sel,
    input  logic [PTR_W-1:0] ptr,
    output logic [CH_W-1:0]  chan
);
    // Single mode uses all select bits; group modes replace the low bits with the slot index.
    always_comb begin
        if (!multi)
            chan = sel;
        else if (len8)
            chan = {sel[CH_W-1:PTR_W], ptr};
        else
            chan = {sel[CH_W-1:PTR_W-1], ptr[PTR_W-2:0]};
    end
endmodule

// File: rtl/adc_result_bank.sv
// Result slots with one completion flag each.
// A write sets the flag of its slot, a read clears it (the write wins a tie), and clr_all clears every flag.
// Assumes: wr_en and clr_all are never high together.
module adc_result_bank #(
    parameter int SLOTS = 8,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  logic [DW-1:0]    wr_data,
    input  logic             clr_all,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_slot,
    output logic [DW-1:0]    rd_data,
    output logic [SLOTS-1:0] flags
);
    logic [DW-1:0] res_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Data register of slot i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_q[i] <= '0;
            else if (wr_en && wr_slot == PTR_W'(i))
                res_q[i] <= wr_data;
        end

        // Completion flag of slot i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (clr_all)
                flags[i] <= 1'b0;
            else if (wr_en && wr_slot == PTR_W'(i))
                flags[i] <= 1'b1;
            else if (rd_en && rd_slot == PTR_W'(i))
                flags[i] <= 1'b0;
        end
    end

    assign rd_data = res_q[rd_slot];

    AST_FLAG_SETS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> flags[$past(wr_slot)]); // R7
endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion sequencer top.
// Runs 4- or 8-conversion passes over one channel or a channel group, handshakes with an
// external converter core (request held until done), and keeps the status word and the interrupt.
// Assumes: the core answers every request with a one-cycle conv_done; config inputs other
// than cfg_* are stable during a sample window.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int DW    = 8,
    parameter int CH_W  = 4,
    parameter int PRS_W = 5,
    parameter int SMP_W = 2,
    parameter int CNT_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_en,
    input  logic                  irq_en,
    input  logic [SMP_W-1:0]      smp_sel,
    input  logic [PRS_W-1:0]      prs_sel,
    input  logic                  cfg_we,
    input  logic                  cfg_len8,
    input  logic                  cfg_scan,
    input  logic                  cfg_multi,
    input  logic [CH_W-1:0]       cfg_sel,
    input  logic                  scf_clr,
    input  logic                  rd_en,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic [DW-1:0]         rd_data,
    output logic                  conv_req,
    output logic [CH_W-1:0]       conv_chan,
    input  logic                  conv_done,
    input  logic [DW-1:0]         conv_data,
    output logic [STAT_W-1:0]     status,
    output logic                  irq
);
    localparam int PTR_W = $clog2(SLOTS);
    localparam int PAD_W = STAT_W - 1 - PTR_W - SLOTS;

    seq_state_e       state_q;
    logic [PTR_W-1:0] ptr_q;
    logic             scf_q;
    logic             len8_q, scan_q, multi_q;
    logic [CH_W-1:0]  sel_q;
    logic [SLOTS-1:0] flags;
    logic             start, store, last, tmr_zero, tmr_load, tmr_dec;

    assign start    = cfg_we && pwr_en;
    assign last     = len8_q ? (ptr_q == PTR_W'(SLOTS - 1)) : (ptr_q == PTR_W'(SLOTS / 2 - 1));
    assign store    = pwr_en && !cfg_we && (state_q == SQ_CONV) && conv_done;
    assign tmr_load = start || (store && !(last && !scan_q));
    assign tmr_dec  = (state_q == SQ_SAMPLE);
    assign conv_req = (state_q == SQ_CONV);

    // Sequencer state, slot pointer and latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ptr_q   <= '0;
            len8_q  <= 1'b0;
            scan_q  <= 1'b0;
            multi_q <= 1'b0;
            sel_q   <= '0;
        end else if (!pwr_en) begin
            state_q <= SQ_IDLE;
        end else if (cfg_we) begin
            state_q <= SQ_SAMPLE;
            ptr_q   <= '0;
            len8_q  <= cfg_len8;
            scan_q  <= cfg_scan;
            multi_q <= cfg_multi;
            sel_q   <= cfg_sel;
        end else begin
            case (state_q)
                SQ_SAMPLE: if (tmr_zero) state_q <= SQ_CONV;
                SQ_CONV: if (conv_done) begin
                    ptr_q   <= last ? '0 : ptr_q + PTR_W'(1);
                    state_q <= (last && !scan_q) ? SQ_IDLE : SQ_SAMPLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Sequence-complete flag: start clears, end of pass sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scf_q <= 1'b0;
        else if (start)
            scf_q <= 1'b0;
        else if (store && last)
            scf_q <= 1'b1;
        else if (scf_clr)
            scf_q <= 1'b0;
    end

    adc_sample_timer #(.PRS_W(PRS_W), .SMP_W(SMP_W), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .dec  (tmr_dec),
        .smp  (smp_sel),
        .prs  (prs_sel),
        .zero (tmr_zero)
    );

    adc_chan_map #(.CH_W(CH_W), .PTR_W(PTR_W)) u_map (
        .multi(multi_q),
        .len8 (len8_q),
        .sel  (sel_q),
        .ptr  (ptr_q),
        .chan (conv_chan)
    );

    adc_result_bank #(.SLOTS(SLOTS), .DW(DW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store),
        .wr_slot(ptr_q),
        .wr_data(conv_data),
        .clr_all(start),
        .rd_en  (rd_en),
        .rd_slot(rd_slot),
        .rd_data(rd_data),
        .flags  (flags)
    );

    assign status = {scf_q, {PAD_W{1'b0}}, ptr_q, flags};
    assign irq    = irq_en && scf_q;

    AST_WRITE_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (status == '0)); // R2
    AST_SHORT_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE && !len8_q) |-> !ptr_q[PTR_W-1]); // R3
    AST_GROUP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && multi_q && !len8_q) |-> (conv_chan[CH_W-1:CH_W-2] == sel_q[CH_W-1:CH_W-2])); // R5
    AST_NO_REQ_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_en) |-> !conv_req); // R10
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0, irq_en = 1'b0;
    logic [1:0] smp_sel = '0;
    logic [4:0] prs_sel = 5'd1;
    logic       cfg_we = 1'b0, cfg_len8 = 1'b0, cfg_scan = 1'b0, cfg_multi = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic       scf_clr = 1'b0, rd_en = 1'b0;
    logic [2:0] rd_slot = '0;
    logic [7:0] rd_data;
    logic       conv_req;
    logic [3:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = '0;
    logic [15:0] status;
    logic       irq;

    int n_checks = 0, n_fail = 0, cycles = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .irq_en(irq_en),
        .smp_sel(smp_sel), .prs_sel(prs_sel), .cfg_we(cfg_we), .cfg_len8(cfg_len8),
        .cfg_scan(cfg_scan), .cfg_multi(cfg_multi), .cfg_sel(cfg_sel),
        .scf_clr(scf_clr), .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter core stub: answers a request after a few cycles with {channel, sequence}.
    int stub_cnt = 0;
    int stub_seq = 0;
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (stub_cnt > 1) stub_cnt--;
        else if (stub_cnt == 1) begin
            stub_cnt = 0;
            conv_done <= 1'b1;
            conv_data <= {conv_chan, 4'(stub_seq)};
            stub_seq++;
        end else if (conv_req === 1'b1 && conv_done !== 1'b1) stub_cnt = 3;
    end

    // Behavioural reference: phase 0 idle, 1 sampling, 2 converting.
    int m_ph, m_wait, m_ptr, m_scf, m_len, m_scan, m_multi, m_sel;
    bit [7:0] m_flags;
    bit [7:0] m_res [8];

    function automatic int window();
        int d;
        d = (prs_sel >= 1 && prs_sel <= 7) ? 2 * int'(prs_sel) + 2 : 4;
        return (2 << smp_sel) * d;
    endfunction

    function automatic int exp_chan();
        if (m_multi == 0) return m_sel;
        if (m_len == 8) return (m_sel & 8) + m_ptr;
        return (m_sel & 12) + m_ptr;
    endfunction

    always @(posedge clk) begin
        int set_slot;
        bit set_last;
        cycles++;
        set_slot = -1;
        set_last = 0;
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_ptr = 0; m_scf = 0; m_flags = 0;
            m_len = 4; m_scan = 0; m_multi = 0; m_sel = 0;
            for (int i = 0; i < 8; i++) m_res[i] = 0;
        end else begin
            if (!pwr_en) m_ph = 0;
            else if (cfg_we) begin
                m_flags = 0; m_scf = 0; m_ptr = 0; m_ph = 1; m_wait = window() - 1;
                m_len = cfg_len8 ? 8 : 4; m_scan = cfg_scan; m_multi = cfg_multi; m_sel = cfg_sel;
            end else if (m_ph == 1) begin
                if (m_wait == 0) m_ph = 2; else m_wait--;
            end else if (m_ph == 2 && conv_done) begin
                m_res[m_ptr] = conv_data;
                set_slot = m_ptr;
                if (m_ptr == m_len - 1) begin
                    set_last = 1; m_ptr = 0; m_ph = m_scan ? 1 : 0;
                end else begin
                    m_ptr++; m_ph = 1;
                end
                if (m_ph == 1) m_wait = window() - 1;
            end
            if (!(pwr_en && cfg_we)) begin
                if (rd_en && int'(rd_slot) != set_slot) m_flags[rd_slot] = 0;
                if (set_slot >= 0) m_flags[set_slot] = 1;
                if (set_last) m_scf = 1;
                else if (scf_clr) m_scf = 0;
            end
        end
    end

    // Per-cycle comparison, away from the clock edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk(status[15] == 1'(m_scf), "R8 complete flag", status[15], m_scf);
            chk(int'(status[10:8]) == m_ptr, "R6 slot pointer", status[10:8], m_ptr);
            chk(status[7:0] == m_flags, "R7 slot flags", status[7:0], m_flags);
            chk(status[14:11] == 4'd0, "R6 pad bits", status[14:11], 0);
            chk(conv_req == (m_ph == 2), "R9 request timing", conv_req, m_ph == 2);
            chk(irq == (irq_en && m_scf != 0), "R11 interrupt", irq, irq_en && m_scf != 0);
            if (m_ph == 2)
                chk(int'(conv_chan) == exp_chan(), "R4/R5 channel select", conv_chan, exp_chan());
            if (rd_en)
                chk(rd_data == m_res[rd_slot], "R12 result read", rd_data, m_res[rd_slot]);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic start_seq(input bit l8, input bit sc, input bit mu, input int sel,
                             input int smp, input int prs);
        @(negedge clk);
        cfg_len8 = l8; cfg_scan = sc; cfg_multi = mu; cfg_sel = 4'(sel);
        smp_sel = 2'(smp); prs_sel = 5'(prs); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_scf(input string tag);
        int n = 0;
        while (status[15] !== 1'b1 && n < 20000) begin
            @(negedge clk); #3; n++;
        end
        chk(status[15] === 1'b1, tag, status[15], 1);
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rd_en = 1'b1; rd_slot = 3'(i);
        end
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk(status == 16'd0 && conv_req == 1'b0 && irq == 1'b0, "R1 reset state", status, 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: unpowered write is ignored.
        begin
            bit seen = 0;
            start_seq(0, 0, 0, 5, 0, 1);
            repeat (40) begin @(negedge clk); #3; if (conv_req) seen = 1; end
            chk(!seen && status == 16'd0, "R10 unpowered ignore", {seen, status}, 0);
        end
        @(negedge clk); pwr_en = 1'b1;

        // Single channel, four conversions.
        start_seq(0, 0, 0, 5, 0, 1);
        wait_scf("R8 one-shot complete");
        repeat (20) @(negedge clk);
        #3; chk(status[7:0] == 8'h0F && conv_req == 1'b0, "R3 four slots then idle", status[7:0], 8'h0F);
        @(negedge clk); rd_en = 1'b1; rd_slot = 3'd1;
        @(negedge clk); rd_en = 1'b0; #3;
        chk(status[7:0] == 8'h0D, "R7 read clears flag", status[7:0], 8'h0D);
        read_all();

        // Channel group of four, interrupt enabled.
        irq_en = 1'b1;
        start_seq(0, 0, 1, 6, 1, 2);
        wait_scf("R8 group complete");
        chk(irq == 1'b1, "R11 irq raised", irq, 1);
        @(negedge clk); scf_clr = 1'b1;
        @(negedge clk); scf_clr = 1'b0; #3;
        chk(status[15] == 1'b0 && irq == 1'b0, "R8 write-one clear", status[15], 0);
        read_all();

        // Group of eight, illegal divider code 0.
        start_seq(1, 0, 1, 11, 1, 0);
        wait_scf("R8 eight-group complete");
        chk(status[7:0] == 8'hFF, "R3 eight slots", status[7:0], 8'hFF);
        read_all();

        // Single channel, eight conversions, illegal divider code 9.
        start_seq(1, 0, 0, 13, 0, 9);
        wait_scf("R4 single eight complete");
        read_all();

        // Continuous scan, then abort mid-pass.
        start_seq(0, 1, 1, 0, 0, 3);
        wait_scf("R8 first scan pass");
        @(negedge clk); scf_clr = 1'b1;
        @(negedge clk); scf_clr = 1'b0;
        wait_scf("R8 scan repeats");
        while (status[10:8] != 3'd2) @(negedge clk);
        start_seq(0, 0, 0, 3, 3, 7);
        #3; chk(status == 16'd0, "R2 abort clears status", status, 0);
        wait_scf("R9 slow window complete");
        read_all();

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule